// File: doc/BRIEF.md
# Data-Line Ready Tracker

This block keeps one flag, `not_busy`, which tells the host controller whether a new data transfer may begin. A card response that opens a data transfer clears the flag. The event that sets it again depends on the kind of transfer.

For a write, the card holds DAT0 low while none of its receive buffers is free. The tracker waits a fixed number of bit clocks after each CRC status token and then samples DAT0. It sets the flag on the first sample where the line is high.

For reads, the flag sets on one of three events, chosen by the read mode latched at the response:
- the end of the only block, for a single-block read;
- the end of the last block, for a read with a preset block count;
- the end of the stop-transmission command, for an open-ended read.

A response that ends a command with no data phase leaves the flag alone. Shifting data and generating or checking CRC are done elsewhere. All inputs are single-cycle strobes or levels sampled in the tracker's clock domain. `bit_tick` marks one bit clock of the card bus.

Top module: `dat_ready_tracker`

## Requirements
- R1: After reset, `not_busy` is 1.
- R2: A `rsp_end` pulse with `rsp_has_data`=1 clears `not_busy` on the next cycle. It also latches the transfer type: `xfer_wr`=1 means write; for reads, `rd_mode` 2'b00 means single block, 2'b01 means counted, and 2'b10 or 2'b11 means open-ended. The count `blk_count` is latched at the same time. The response takes priority over any other event in the same cycle.
- R3: A `rsp_end` pulse with `rsp_has_data`=0 leaves `not_busy` unchanged, whether it is 0 or 1.
- R4: In a write, DAT0 is ignored on the first GUARD_BITS `bit_tick`s after a `crc_tok_end` pulse. From then on, the first `bit_tick` with `dat0`=1 sets `not_busy` on the next cycle, and ticks with `dat0`=0 keep it at 0.
- R5: `dat0` is only looked at in cycles where `bit_tick`=1. A high line without a tick never sets the flag.
- R6: After DAT0 has been released within a write, a further `crc_tok_end` pulse clears `not_busy` again and restarts the guard and busy detection.
- R7: In a single-block read, the first `blk_end` pulse sets `not_busy`.
- R8: In a counted read, each `blk_end` pulse uses up one block. Only the block end that brings the remaining count to zero sets `not_busy`. A latched count of 0 behaves like a count of 1.
- R9: In an open-ended read, `blk_end` pulses have no effect, and a `stop_end` pulse sets `not_busy`.
- R10: Events that do not belong to the active transfer type leave `not_busy` unchanged, as do all events while no transfer is open. This covers `stop_end` outside an open-ended read, `blk_end` in a write, and `crc_tok_end` or bit ticks in a read or before a write opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rsp_end | input | 1 | Pulse: card response has ended |
| rsp_has_data | input | 1 | The ending command opens a data transfer |
| xfer_wr | input | 1 | Transfer direction, 1 = write |
| rd_mode | input | 2 | Read type: 00 single, 01 counted, 1x open-ended |
| blk_count | input | CNT_W | Number of blocks for a counted read, latched at `rsp_end` |
| blk_end | input | 1 | Pulse: end of one received data block |
| stop_end | input | 1 | Pulse: stop-transmission command has ended |
| crc_tok_end | input | 1 | Pulse: end of the CRC status token of a written block |
| bit_tick | input | 1 | Strobe: one bit clock of the card bus |
| dat0 | input | 1 | Sampled DAT0 level |
| not_busy | output | 1 | 1 = a new data transfer may start |

## Verification
The bench sweeps the preset block count from 0 to 6 and checks the flag after every block end. A counter that set the flag early would fail on counts above one, and one that underflowed would hang on a count of zero.

The write path is swept over busy lengths of zero to four sampled ticks, with DAT0 held high through the guard window and between ticks. A design that sampled too soon, or that sampled without a tick, would set the flag early.

Stray strobes are sent in every transfer type, and a new response arrives in the same cycle as a stop. These catch decoding that reacts to the wrong event or gets the priority wrong. A non-data response is sent both while idle and in mid-transfer, and must leave the flag untouched.

// File: rtl/dat_rdy_pkg.sv
package dat_rdy_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_WR_XFER,
        ST_WR_GUARD,
        ST_WR_BUSY,
        ST_WR_FREE,
        ST_RD_SINGLE,
        ST_RD_COUNT,
        ST_RD_OPEN
    } trk_state_e;

    localparam logic [1:0] RD_SINGLE  = 2'b00;
    localparam logic [1:0] RD_COUNTED = 2'b01;

    typedef struct packed {
        trk_state_e st;
        logic       nb;
    } trk_reg_t;

endpackage

// File: rtl/dat_guard_timer.sv
module dat_guard_timer #(
    parameter int GUARD_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int GW = (GUARD_BITS < 2) ? 1 : $clog2(GUARD_BITS + 1);

    logic [GW-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == GW'(GUARD_BITS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the guard count never runs past its last value
    p_guard_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= GW'(GUARD_BITS - 1));

endmodule

// File: rtl/dat_blk_counter.sv
module dat_blk_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // A count of one or zero means the next block end is the final one
    assign last = (cnt_q <= CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: the remaining count saturates at zero and never wraps
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/dat_ready_tracker.sv
module dat_ready_tracker
    import dat_rdy_pkg::*;
#(
    parameter int GUARD_BITS = 2,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsp_end,
    input  logic             rsp_has_data,
    input  logic             xfer_wr,
    input  logic [1:0]       rd_mode,
    input  logic [CNT_W-1:0] blk_count,
    input  logic             blk_end,
    input  logic             stop_end,
    input  logic             crc_tok_end,
    input  logic             bit_tick,
    input  logic             dat0,
    output logic             not_busy
);
    trk_reg_t r_d, r_q;
    logic     data_rsp;
    logic     guard_clr, guard_tick, guard_last;
    logic     cnt_dec, cnt_last;

    assign data_rsp   = rsp_end && rsp_has_data;
    assign guard_clr  = crc_tok_end &&
                        (r_q.st == ST_WR_XFER || r_q.st == ST_WR_FREE);
    assign guard_tick = bit_tick && (r_q.st == ST_WR_GUARD);
    assign cnt_dec    = blk_end && (r_q.st == ST_RD_COUNT);

    dat_guard_timer #(.GUARD_BITS(GUARD_BITS)) guard_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (guard_clr),
        .tick  (guard_tick),
        .last  (guard_last)
    );

    dat_blk_counter #(.CNT_W(CNT_W)) blkcnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (data_rsp),
        .load_val (blk_count),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_WR_XFER:   if (crc_tok_end) r_d.st = ST_WR_GUARD;
            ST_WR_GUARD:  if (bit_tick && guard_last) r_d.st = ST_WR_BUSY;
            ST_WR_BUSY:   if (bit_tick && dat0) begin
                              r_d.st = ST_WR_FREE;
                              r_d.nb = 1'b1;
                          end
            ST_WR_FREE:   if (crc_tok_end) begin
                              r_d.st = ST_WR_GUARD;
                              r_d.nb = 1'b0;
                          end
            ST_RD_SINGLE: if (blk_end) begin
                              r_d.st = ST_READY;
                              r_d.nb = 1'b1;
                          end
            ST_RD_COUNT:  if (blk_end && cnt_last) begin
                              r_d.st = ST_READY;
                              r_d.nb = 1'b1;
                          end
            ST_RD_OPEN:   if (stop_end) begin
                              r_d.st = ST_READY;
                              r_d.nb = 1'b1;
                          end
            default:      ;
        endcase
        // A data response opens a new transfer and overrides everything else
        if (data_rsp) begin
            r_d.nb = 1'b0;
            if (xfer_wr)                    r_d.st = ST_WR_XFER;
            else if (rd_mode == RD_SINGLE)  r_d.st = ST_RD_SINGLE;
            else if (rd_mode == RD_COUNTED) r_d.st = ST_RD_COUNT;
            else                            r_d.st = ST_RD_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_READY;
            r_q.nb <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign not_busy = r_q.nb;

    // R2: a data response always clears the flag
    p_rsp_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_rsp |=> !not_busy);

    // R3: a non-data response on its own does not move the flag
    p_nodata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_end && !rsp_has_data && !blk_end && !stop_end && !crc_tok_end && !bit_tick)
        |=> $stable(not_busy));

    // R4: the flag only rises from the busy wait on a high sampled DAT0
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WR_BUSY && bit_tick && dat0 && !data_rsp) |=> not_busy);

    // R5: without a bit tick the write path never raises the flag
    p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WR_BUSY && !bit_tick) |=> !not_busy);

    // R7: a single-block read is done at its block end
    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD_SINGLE && blk_end && !data_rsp) |=> not_busy);

    // R8: earlier blocks of a counted read keep the flag low
    p_count_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD_COUNT && blk_end && !cnt_last) |=> !not_busy);

    // R9: the stop command ends an open-ended read
    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD_OPEN && stop_end && !data_rsp) |=> not_busy);

endmodule

// File: tb/dat_ready_tracker_tb_top.sv
module dat_ready_tracker_tb_top;
    localparam int G  = 2;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rsp_end = 0, rsp_has_data = 0, xfer_wr = 0;
    logic [1:0] rd_mode = 2'b00;
    logic [CW-1:0] blk_count = '0;
    logic blk_end = 0, stop_end = 0, crc_tok_end = 0, bit_tick = 0, dat0 = 1;
    logic not_busy;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    dat_ready_tracker #(.GUARD_BITS(G), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rsp_end(rsp_end), .rsp_has_data(rsp_has_data),
        .xfer_wr(xfer_wr), .rd_mode(rd_mode), .blk_count(blk_count),
        .blk_end(blk_end), .stop_end(stop_end), .crc_tok_end(crc_tok_end),
        .bit_tick(bit_tick), .dat0(dat0), .not_busy(not_busy)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_pulses();
        rsp_end = 0; blk_end = 0; stop_end = 0; crc_tok_end = 0; bit_tick = 0;
    endtask

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (not_busy !== exp) begin
            fails++;
            $display("FAIL %s: not_busy actual=%b expected=%b", tag, not_busy, exp);
        end
    endtask

    task automatic open_xfer(input logic wr, input logic [1:0] mode, input int n);
        rsp_end = 1; rsp_has_data = 1; xfer_wr = wr; rd_mode = mode;
        blk_count = CW'(n);
        cyc(); clear_pulses();
    endtask

    task automatic tick(input logic d);
        bit_tick = 1; dat0 = d; cyc(); bit_tick = 0;
    endtask

    task automatic pulse_blk();  blk_end = 1;     cyc(); clear_pulses(); endtask
    task automatic pulse_stop(); stop_end = 1;    cyc(); clear_pulses(); endtask
    task automatic pulse_tok();  crc_tok_end = 1; cyc(); clear_pulses(); endtask
    task automatic nodata_rsp();
        rsp_end = 1; rsp_has_data = 0; cyc(); clear_pulses();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk(1'b1, "R1 in reset");
        cyc(); rst_n = 1; cyc();
        chk(1'b1, "R1 after reset");

        // R3 and R10 while idle
        nodata_rsp();  chk(1'b1, "R3 idle non-data response");
        pulse_blk();   chk(1'b1, "R10 idle blk_end");
        pulse_stop();  chk(1'b1, "R10 idle stop_end");
        pulse_tok();   chk(1'b1, "R10 idle crc_tok_end");

        // Single-block read
        open_xfer(0, 2'b00, 0); chk(1'b0, "R2 single read opens");
        pulse_stop();  chk(1'b0, "R10 stop in single read");
        pulse_tok();   chk(1'b0, "R10 token in single read");
        tick(1);       chk(1'b0, "R10 tick in single read");
        pulse_blk();   chk(1'b1, "R7 single block end");

        // Counted read sweep
        for (int n = 0; n <= 6; n++) begin
            int need;
            need = (n == 0) ? 1 : n;
            open_xfer(0, 2'b01, n); chk(1'b0, "R2 counted read opens");
            pulse_stop(); chk(1'b0, "R10 stop in counted read");
            for (int k = 1; k <= need; k++) begin
                pulse_blk();
                chk((k == need) ? 1'b1 : 1'b0, $sformatf("R8 count=%0d block %0d", n, k));
            end
        end

        // Open-ended read, both encodings
        for (int m = 2; m <= 3; m++) begin
            open_xfer(0, 2'(m), 3); chk(1'b0, "R2 open read opens");
            for (int k = 0; k < 4; k++) begin
                pulse_blk(); chk(1'b0, "R9 blk_end ignored in open read");
            end
            nodata_rsp(); chk(1'b0, "R3 non-data response mid-read");
            pulse_stop(); chk(1'b1, "R9 stop ends open read");
        end

        // Priority: new data response with a stop in the same cycle
        open_xfer(0, 2'b10, 0);
        stop_end = 1; open_xfer(0, 2'b10, 0);
        chk(1'b0, "R2 response beats stop");
        pulse_stop(); chk(1'b1, "R9 stop after priority case");

        // Write sweep over busy lengths
        for (int L = 0; L <= 4; L++) begin
            open_xfer(1, 2'b00, 0); chk(1'b0, "R2 write opens");
            tick(1);      chk(1'b0, "R10 tick before token");
            pulse_blk();  chk(1'b0, "R10 blk_end in write");
            pulse_stop(); chk(1'b0, "R10 stop in write");
            for (int rep = 0; rep < 2; rep++) begin
                pulse_tok(); chk(1'b0, "R6 token clears or keeps low");
                for (int g = 0; g < G; g++) begin
                    tick(1); chk(1'b0, "R4 guard tick ignores DAT0");
                end
                for (int b = 0; b < L; b++) begin
                    tick(0); chk(1'b0, "R4 busy held low");
                end
                dat0 = 1; cyc(); cyc(); chk(1'b0, "R5 no tick no release");
                tick(1); chk(1'b1, "R4 release sets flag");
                dat0 = 0; cyc(); chk(1'b1, "R6 flag holds after release");
            end
            dat0 = 1;
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule